// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block decides which of several pending interrupt requests a small CPU core services next. Each maskable source has an enable bit and a 2-bit software level that software can program. Each source also has a fixed hardware rank, and no two sources share a rank. The block also handles two non-maskable requests: a software trap and a reset request. A request pulse sets a pending latch. The latch holds the request until the core acknowledges it, or until the source's clear sequence discards it.

Arbitration has two stages. First, the highest software level among the eligible sources wins. Second, if several sources share that level, the hardware rank picks one of them. A maskable source is eligible only when it is pending, enabled, and its level is strictly above the core's current 2-bit level. The non-maskable requests bypass that comparison and outrank every maskable level; a reset request beats a trap.

The block reports the result on three outputs:
- a take strobe;
- the winning vector index;
- the level the core must load on entry, which is always 3.

A wake output tells the halt logic that something is waiting.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After `rst_n` is low, every pending latch is cleared. `take` and `wake` are both 0 until a new request arrives.
- R2: A maskable source i is a candidate only when all three conditions hold: its latch is set, `src_en[i]` is 1, and its level `src_lvl[2i+1:2i]` is strictly greater than `cur_lvl`. Otherwise it stays pending and can be taken later. This means a level 3 source is never taken while `cur_lvl` is 3.
- R3: Among the candidates, the highest software level wins. When levels tie, the lowest source index wins, because index 0 has the highest hardware rank. Maskable source i reports `vec_idx` = i+2.
- R4: A pending trap is taken with `vec_idx` = 1 for any `cur_lvl`, ahead of every maskable source.
- R5: A pending reset request is taken with `vec_idx` = 0, ahead of the trap and every maskable source.
- R6: While `take` is 1, `new_lvl` is 3.
- R7: An `ack` pulse while `take` is 1 clears only the latch of the reported winner. A request arriving in the same cycle, including one from the winner itself, stays pending for the next decision.
- R8: `src_clr[i]` clears the latch of source i and discards its pending request. The clear takes precedence over a request on the same source in the same cycle.
- R9: `wake` is 1 when a non-maskable request is pending, or when any pending maskable source is enabled. This holds whatever `cur_lvl` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | N_SRC | Request pulse per maskable source |
| src_en | input | N_SRC | Enable per maskable source |
| src_lvl | input | 2*N_SRC | Software level, 2 bits per source; source i uses bits [2i+1:2i] |
| src_clr | input | N_SRC | Clear-sequence pulse per maskable source |
| trap_req | input | 1 | Software trap pulse |
| reset_req | input | 1 | Reset request pulse |
| cur_lvl | input | 2 | Current level from the core's condition register |
| ack | input | 1 | Core accepts the reported winner |
| take | output | 1 | A request is ready to be taken |
| vec_idx | output | VEC_W | Winner: 0 reset, 1 trap, i+2 maskable source i |
| new_lvl | output | 2 | Level to load on entry |
| wake | output | 1 | Wake-up request for halt mode |

## Verification
Two pairs of functions can land in the same cycle:
- the acknowledge that clears the winner's latch and a fresh request on that same source;
- a clear sequence and a request on the same source.

The bench drives both members of each pair on one clock edge. It then judges the outcome at the ports after that edge. The first pair must leave the source reported again. The second pair must leave `take` low with every source enabled. The selection itself is swept over every combination of level assignments, enables and current level, and each result is compared with a value the bench computes arithmetically.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVL_W = 2;
  localparam logic [LVL_W-1:0] LVL_TOP = '1;
  localparam int NMI_CNT = 2;  // bit 0 reset request, bit 1 trap

  function automatic logic lvl_gt(input logic [LVL_W-1:0] a, input logic [LVL_W-1:0] b);
    return a > b;
  endfunction

  function automatic logic [LVL_W-1:0] lvl_of(input int idx, input logic [63:0] flat);
    return flat[idx*LVL_W +: LVL_W];
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] ack_clr_i,
  input  logic [W-1:0] seq_clr_i,
  output logic [W-1:0] pend_o
);
  for (genvar g = 0; g < W; g++) begin : g_latch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o[g] <= 1'b0;
      else        pend_o[g] <= ((pend_o[g] & ~ack_clr_i[g]) | set_i[g]) & ~seq_clr_i[g];
    end

    // R7
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_clr_i[g] && !set_i[g]) |=> !pend_o[g]);
    // R8
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_clr_i[g] |=> !pend_o[g]);
  end

  // R7
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_clr_i));
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import prio_irq_pkg::*;
#(
  parameter int N     = 4,
  parameter int VEC_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N+NMI_CNT-1:0]  pend_i,
  input  logic [N-1:0]          en_i,
  input  logic [N*LVL_W-1:0]    lvl_i,
  input  logic [LVL_W-1:0]      cur_i,
  output logic                  take_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic [LVL_W-1:0]      win_lvl_o
);
  logic             found;
  logic [LVL_W-1:0] best;
  logic [LVL_W-1:0] l;

  always_comb begin
    found = 1'b0;
    best  = '0;
    l     = '0;
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      l = lvl_i[i*LVL_W +: LVL_W];
      if (pend_i[i+NMI_CNT] && en_i[i] && lvl_gt(l, cur_i) &&
          (!found || !lvl_gt(best, l))) begin
        found = 1'b1;
        best  = l;
        vec_o = VEC_W'(i + NMI_CNT);
      end
    end
    if (pend_i[1]) begin
      found = 1'b1;
      best  = LVL_TOP;
      vec_o = VEC_W'(1);
    end
    if (pend_i[0]) begin
      found = 1'b1;
      best  = LVL_TOP;
      vec_o = '0;
    end
    take_o    = found;
    win_lvl_o = best;
  end

  // R2
  mask_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o >= VEC_W'(NMI_CNT)) |-> lvl_gt(win_lvl_o, cur_i));
  // R5
  rst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_i[0] |-> (take_o && vec_o == '0));
  // R4
  trap_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i[1] && !pend_i[0]) |-> (take_o && vec_o == VEC_W'(1)));
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 4,
  localparam int VEC_W = $clog2(N_SRC + NMI_CNT),
  localparam int TOT   = N_SRC + NMI_CNT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       src_req,
  input  logic [N_SRC-1:0]       src_en,
  input  logic [2*N_SRC-1:0]     src_lvl,
  input  logic [N_SRC-1:0]       src_clr,
  input  logic                   trap_req,
  input  logic                   reset_req,
  input  logic [1:0]             cur_lvl,
  input  logic                   ack,
  output logic                   take,
  output logic [VEC_W-1:0]       vec_idx,
  output logic [1:0]             new_lvl,
  output logic                   wake
);
  logic [TOT-1:0]   pend;
  logic [TOT-1:0]   set_all;
  logic [TOT-1:0]   seq_clr;
  logic [TOT-1:0]   ack_clr;
  logic [LVL_W-1:0] win_lvl;

  assign set_all = {src_req, trap_req, reset_req};
  assign seq_clr = {src_clr, {NMI_CNT{1'b0}}};
  assign ack_clr = (take && ack) ? (TOT'(1) << vec_idx) : '0;

  irq_pend_bank #(.W(TOT)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_all),
    .ack_clr_i (ack_clr),
    .seq_clr_i (seq_clr),
    .pend_o    (pend)
  );

  irq_pick #(.N(N_SRC), .VEC_W(VEC_W)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend),
    .en_i      (src_en),
    .lvl_i     (src_lvl),
    .cur_i     (cur_lvl),
    .take_o    (take),
    .vec_o     (vec_idx),
    .win_lvl_o (win_lvl)
  );

  assign new_lvl = take ? LVL_TOP : cur_lvl;
  assign wake    = (|pend[NMI_CNT-1:0]) | (|(pend[TOT-1:NMI_CNT] & src_en));

  // R7
  ack_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> take);
  // R9
  nmi_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend[NMI_CNT-1:0]) |-> wake);
  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!take && !wake));
endmodule

// File: tb/test_prio_irq_arbiter.sv
module test_prio_irq_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int VW = $clog2(N + 2);

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] src_req = '0, src_en = '0, src_clr = '0;
  logic [2*N-1:0] src_lvl = '0;
  logic trap_req = 0, reset_req = 0, ack = 0;
  logic [1:0] cur_lvl = '0;
  logic take, wake;
  logic [VW-1:0] vec_idx;
  logic [1:0] new_lvl;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  prio_irq_arbiter #(.N_SRC(N)) i_prio_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
    .src_lvl(src_lvl), .src_clr(src_clr), .trap_req(trap_req),
    .reset_req(reset_req), .cur_lvl(cur_lvl), .ack(ack), .take(take),
    .vec_idx(vec_idx), .new_lvl(new_lvl), .wake(wake));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected winner index with all maskable sources pending, -1 for none
  function automatic int exp_vec(input logic [N-1:0] en, input logic [2*N-1:0] lv,
                                 input int cur);
    int best_i = -1;
    int best_l = -1;
    for (int i = 0; i < N; i++) begin
      int l = int'(lv[2*i +: 2]);
      if (en[i] && l > cur && l > best_l) begin
        best_l = l;
        best_i = i;
      end
    end
    return (best_i < 0) ? -1 : best_i + 2;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    while (cyc < 150000 && !done) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      report();
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1; #1;
    // R1 reset state
    chk("R1 take", int'(take), 0);
    chk("R1 wake", int'(wake), 0);

    // exhaustive sweep, all maskable sources latched
    src_req = '1; tick(); src_req = '0;
    for (int c = 0; c < 4; c++)
      for (int e = 0; e < 16; e++)
        for (int lv = 0; lv < 256; lv++) begin
          int ev;
          cur_lvl = 2'(c); src_en = 4'(e); src_lvl = 8'(lv);
          #1;
          ev = exp_vec(src_en, src_lvl, c);
          // R2 R3 selection
          chk("R3 vec", take ? int'(vec_idx) : -1, ev);
          if (take) chk("R6 new_lvl", int'(new_lvl), 3);
          chk("R9 wake", int'(wake), (e != 0) ? 1 : 0);
        end
    tick();
    // R8 clear discards all
    src_clr = '1; tick(); src_clr = '0;
    src_en = '1; cur_lvl = 0; #1;
    chk("R8 clear all", int'(take), 0);

    // R2 disabled source stays pending
    src_en = '0; src_lvl = 8'b00_01_00_00;
    src_req = 4'b0100; tick(); src_req = '0;
    chk("R2 disabled no take", int'(take), 0);
    chk("R9 disabled no wake", int'(wake), 0);
    src_en = 4'b0100; #1;
    chk("R2 enabled later taken", take ? int'(vec_idx) : -1, 4);
    chk("R6 new_lvl", int'(new_lvl), 3);
    cur_lvl = 1; #1;
    chk("R2 equal level blocked", int'(take), 0);
    chk("R9 wake while blocked", int'(wake), 1);

    // R2 level 3 never preempts level 3
    cur_lvl = 3; src_lvl[7:6] = 2'd3; src_en = 4'b1100;
    src_req = 4'b1000; tick(); src_req = '0;
    chk("R2 level3 at level3", int'(take), 0);

    // R4 trap at level 3
    trap_req = 1; tick(); trap_req = 0;
    chk("R4 trap vec", take ? int'(vec_idx) : -1, 1);
    chk("R6 trap new_lvl", int'(new_lvl), 3);
    // R5 reset request beats trap
    reset_req = 1; tick(); reset_req = 0;
    chk("R5 reset vec", take ? int'(vec_idx) : -1, 0);
    // R7 ack removes only the winner
    ack = 1; tick(); ack = 0;
    chk("R7 after reset ack", take ? int'(vec_idx) : -1, 1);
    ack = 1; tick(); ack = 0;
    chk("R7 after trap ack", int'(take), 0);
    chk("R9 maskable still wake", int'(wake), 1);
    cur_lvl = 0; #1;
    chk("R3 higher level wins", take ? int'(vec_idx) : -1, 5);
    // R7 request on winner in ack cycle stays pending
    ack = 1; src_req = 4'b1000; tick(); ack = 0; src_req = '0;
    chk("R7 same-cycle request kept", take ? int'(vec_idx) : -1, 5);
    ack = 1; tick(); ack = 0;
    chk("R7 next winner", take ? int'(vec_idx) : -1, 4);
    // R8 clear beats same-cycle request
    src_clr = 4'b0100; src_req = 4'b0100; tick(); src_clr = '0; src_req = '0;
    src_en = '1; #1;
    chk("R8 clear beats request", int'(take), 0);
    chk("R8 no wake", int'(wake), 0);

    // R3 tie on level: lower index wins
    src_lvl = 8'b10_10_10_10;
    src_req = 4'b0110; tick(); src_req = '0;
    chk("R3 tie lower index", take ? int'(vec_idx) : -1, 3);

    // R1 reset clears latches
    rst_n = 0; #1; tick(); rst_n = 1; #1;
    chk("R1 reset clears take", int'(take), 0);
    chk("R1 reset clears wake", int'(wake), 0);

    done = 1;
    report();
  end
endmodule